// File: doc/BRIEF.md
# Drowsy Cache Line Power Controller

This block models a small direct-mapped cache data array in which every line can drop into a low-leakage state that keeps its contents. Each line has an idle counter, a sleep bit and an activity flag. A line that goes unused for a set number of cycles is put to sleep. A global request can also put all idle lines to sleep at once, and a hold input stops any line from falling asleep.

Requests arrive on a valid/ready port that carries a line index, a read/write select and write data. A request to an awake line is taken in the cycle it is presented. A request to a sleeping line is stalled while the line is woken over a fixed number of cycles. It is then taken normally, and its response is marked with a wake-penalty bit. Responses come one cycle after acceptance. A read returns the stored word and a write echoes the word it stored. A status output gives the number of lines that are asleep.

Top module: `drowsy_cache_ctrl`

## Requirements
- R1: During and after reset, before any request, rspValid is 0, reqReady is 1 and asleepCount is 0.
- R2: A request to an awake line is accepted in the cycle it is presented (reqReady high). rspValid is high exactly one cycle later with rspWakePenalty 0. rspData holds the stored word for a read (reqWrite=0) or the written word for a write (reqWrite=1).
- R3: After the edge that accepts an access to a line, if nothing touches that line again and keepAwake stays low, the line enters sleep at the (IDLE_LIMIT+1)-th following clock edge and not earlier.
- R4: An accepted access to an awake line restarts its idle interval, so the R3 count is measured from the latest access.
- R5: A request to a sleeping line sees reqReady low for exactly WAKE_LAT+1 cycles. It is accepted on the next cycle, and its response carries rspWakePenalty 1.
- R6: A sleeping line keeps its data. A read after wake-up returns the word stored before sleep, and a write that wakes a line is stored like any other write.
- R7: A one-cycle pulse on sleepAll puts every awake line to sleep at the next edge. Exempt are the line named by a valid request and any line whose activity flag is set.
- R8: The activity flag of a line is set by the edge that accepts an access to it and is cleared one edge later. A sleepAll pulse in the cycle right after an access therefore leaves that line awake.
- R9: While keepAwake is high, no line enters sleep through the idle timeout or sleepAll. Lines already asleep stay asleep until they are accessed.
- R10: asleepCount equals the number of lines currently in sleep.
- R11: rspWakePenalty is set only for the first access after a wake-up. The next access to the same, now awake, line has penalty 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqLine | input | IDX_W | Line index of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response present |
| rspData | output | DATA_W | Read data or echoed write data |
| rspWakePenalty | output | 1 | Response was delayed by a wake-up |
| sleepAll | input | 1 | Put all idle lines to sleep |
| keepAwake | input | 1 | Block any new sleep entry |
| asleepCount | output | CNT_W | Number of sleeping lines |

## Verification
A wrong sleep bit shows up at the ports within one edge. asleepCount moves off the expected population, and a stall appears or goes missing on the next request to that line. An idle counter that is off by one moves the asleepCount step by one cycle, so the bench samples both sides of the expected edge. Lost retention shows as wrong read data on the first access after a wake. A stuck penalty latch shows on the access that follows.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;
  // Strobes from control to datapath, one set per accepted request
  typedef struct packed {
    logic accept;
    logic write;
    logic penalty;
  } dpStrobe_t;
endpackage

// File: rtl/drowsy_line_mon.sv
module drowsy_line_mon #(
  parameter int IDLE_LIMIT = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic accessHit,
  input  logic wakeHit,
  input  logic busy,
  input  logic sleepAll,
  input  logic keepAwake,
  output logic asleep,
  output logic activeFlag
);
  localparam int CNT_W = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(IDLE_LIMIT - 1);

  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asleep     <= 1'b0;
      activeFlag <= 1'b0;
      idleCnt    <= '0;
    end else if (wakeHit) begin
      asleep     <= 1'b0;
      activeFlag <= 1'b1;
      idleCnt    <= '0;
    end else if (accessHit) begin
      activeFlag <= 1'b1;
      idleCnt    <= '0;
    end else if (activeFlag) begin
      activeFlag <= 1'b0;
      idleCnt    <= '0;
    end else if (asleep) begin
      idleCnt    <= idleCnt;
    end else if (keepAwake) begin
      idleCnt    <= '0;
    end else if (sleepAll && !busy) begin
      asleep     <= 1'b1;
    end else if (idleCnt == LIMIT_M1) begin
      asleep     <= 1'b1;
    end else begin
      idleCnt    <= idleCnt + 1'b1;
    end
  end
endmodule

// File: rtl/drowsy_ctrl.sv
module drowsy_ctrl
  import drowsy_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int WAKE_LAT  = 2,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [IDX_W-1:0]     reqLine,
  input  logic                 reqWrite,
  input  logic [NUM_LINES-1:0] lineAsleep,
  output logic                 reqReady,
  output dpStrobe_t            strobe,
  output logic [NUM_LINES-1:0] acceptVec,
  output logic [NUM_LINES-1:0] wakeVec,
  output logic [NUM_LINES-1:0] busyVec
);
  localparam int WCNT_W = (WAKE_LAT > 1) ? $clog2(WAKE_LAT) : 1;

  typedef enum logic {ST_SERVE, ST_WAKE} ctrlState_t;

  ctrlState_t       state;
  logic [WCNT_W-1:0] wakeCnt;
  logic [IDX_W-1:0]  wakeIdx;
  logic              penaltyPend;
  logic              hitsSleeper;
  logic              accept;
  logic              wakeDone;

  assign hitsSleeper = reqValid && lineAsleep[reqLine];
  assign reqReady    = (state == ST_SERVE) && !hitsSleeper;
  assign accept      = reqValid && reqReady;
  assign wakeDone    = (state == ST_WAKE) && (wakeCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_SERVE;
      wakeCnt     <= '0;
      wakeIdx     <= '0;
      penaltyPend <= 1'b0;
    end else begin
      case (state)
        ST_SERVE: begin
          if (accept) penaltyPend <= 1'b0;
          if (hitsSleeper) begin
            state   <= ST_WAKE;
            wakeCnt <= WCNT_W'(WAKE_LAT - 1);
            wakeIdx <= reqLine;
          end
        end
        default: begin
          if (wakeDone) begin
            state       <= ST_SERVE;
            penaltyPend <= 1'b1;
          end else begin
            wakeCnt <= wakeCnt - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.accept  = accept;
    strobe.write   = reqWrite;
    strobe.penalty = penaltyPend;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
    assign acceptVec[i] = accept && (reqLine == IDX_W'(i));
    assign wakeVec[i]   = wakeDone && (wakeIdx == IDX_W'(i));
    assign busyVec[i]   = (reqValid && (reqLine == IDX_W'(i))) ||
                          ((state == ST_WAKE) && (wakeIdx == IDX_W'(i)));
  end
endmodule

// File: rtl/drowsy_datapath.sv
module drowsy_datapath
  import drowsy_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [IDX_W-1:0]     reqLine,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [NUM_LINES-1:0] lineAsleep,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspData,
  output logic                 rspWakePenalty
);
  logic [DATA_W-1:0] lineMem [NUM_LINES];
  logic [DATA_W-1:0] readWord;

  // A sleeping line cannot be sensed: its output is forced low
  assign readWord = lineAsleep[reqLine] ? '0 : lineMem[reqLine];

  always_ff @(posedge clk) begin
    if (strobe.accept && strobe.write) lineMem[reqLine] <= reqWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid       <= 1'b0;
      rspData        <= '0;
      rspWakePenalty <= 1'b0;
    end else begin
      rspValid       <= strobe.accept;
      rspWakePenalty <= strobe.accept && strobe.penalty;
      if (strobe.accept) rspData <= strobe.write ? reqWdata : readWord;
    end
  end
endmodule

// File: rtl/drowsy_cache_ctrl.sv
module drowsy_cache_ctrl
  import drowsy_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int DATA_W     = 32,
  parameter int IDLE_LIMIT = 64,
  parameter int WAKE_LAT   = 2,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W     = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [IDX_W-1:0]  reqLine,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspWakePenalty,
  input  logic              sleepAll,
  input  logic              keepAwake,
  output logic [CNT_W-1:0]  asleepCount
);
  dpStrobe_t            strobe;
  logic [NUM_LINES-1:0] asleepVec;
  logic [NUM_LINES-1:0] flagVec;
  logic [NUM_LINES-1:0] acceptVec;
  logic [NUM_LINES-1:0] wakeVec;
  logic [NUM_LINES-1:0] busyVec;

  drowsy_ctrl #(.NUM_LINES(NUM_LINES), .WAKE_LAT(WAKE_LAT)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine),
    .reqWrite(reqWrite), .lineAsleep(asleepVec), .reqReady(reqReady),
    .strobe(strobe), .acceptVec(acceptVec), .wakeVec(wakeVec), .busyVec(busyVec)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    drowsy_line_mon #(.IDLE_LIMIT(IDLE_LIMIT)) mon_i (
      .clk(clk), .rstN(rstN), .accessHit(acceptVec[i]), .wakeHit(wakeVec[i]),
      .busy(busyVec[i]), .sleepAll(sleepAll), .keepAwake(keepAwake),
      .asleep(asleepVec[i]), .activeFlag(flagVec[i])
    );
  end

  drowsy_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLine(reqLine),
    .reqWdata(reqWdata), .lineAsleep(asleepVec), .rspValid(rspValid),
    .rspData(rspData), .rspWakePenalty(rspWakePenalty)
  );

  always_comb begin
    asleepCount = '0;
    for (int i = 0; i < NUM_LINES; i++) asleepCount = asleepCount + CNT_W'(asleepVec[i]);
  end
endmodule

// File: rtl/drowsy_cache_ctrl_chk.sv
module drowsy_cache_ctrl_chk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [IDX_W-1:0]     reqLine,
  input logic                 rspValid,
  input logic                 rspWakePenalty,
  input logic                 keepAwake,
  input logic [NUM_LINES-1:0] asleepVec
);
  // R5: a sleeping target is never served directly
  a_r5_stall_sleeper: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && asleepVec[reqLine]) |-> !reqReady);

  // R2: every accepted request gets a response next cycle
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R2: no response without an accepted request
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

  // R9: no new sleeper while the hold input is high
  a_r9_hold_blocks_sleep: assert property (@(posedge clk) disable iff (!rstN)
    keepAwake |=> ((asleepVec & ~$past(asleepVec)) == '0));

  // R11: penalty never on two back-to-back responses
  a_r11_penalty_single: assert property (@(posedge clk) disable iff (!rstN)
    rspWakePenalty |=> !rspWakePenalty);

  // R8: an accessed line is still awake one edge after the access
  a_r8_flag_guard: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##1 !asleepVec[$past(reqLine, 2)]);
endmodule

bind drowsy_cache_ctrl drowsy_cache_ctrl_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqLine(reqLine), .rspValid(rspValid), .rspWakePenalty(rspWakePenalty),
  .keepAwake(keepAwake), .asleepVec(asleepVec)
);

// File: tb/drowsy_cache_ctrl_tb_top.sv
module drowsy_cache_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 8;
  localparam int DW   = 32;
  localparam int IDLE = 64;
  localparam int WL   = 2;
  localparam int IW   = $clog2(NL);
  localparam int CW   = $clog2(NL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [IW-1:0] reqLine = '0;
  logic [DW-1:0] reqWdata = '0;
  logic rspValid, rspWakePenalty;
  logic [DW-1:0] rspData;
  logic sleepAll = 1'b0, keepAwake = 1'b0;
  logic [CW-1:0] asleepCount;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drowsy_cache_ctrl #(.NUM_LINES(NL), .DATA_W(DW), .IDLE_LIMIT(IDLE), .WAKE_LAT(WL)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLine(reqLine), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspWakePenalty(rspWakePenalty),
    .sleepAll(sleepAll), .keepAwake(keepAwake), .asleepCount(asleepCount)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one request starting at a negedge; returns at the negedge after acceptance
  task automatic doReq(input int line, input bit wr, input logic [DW-1:0] wd,
                       output int stalls, output logic [DW-1:0] rd, output bit pen,
                       output bit vld);
    stalls = 0;
    reqValid = 1'b1; reqLine = IW'(line); reqWrite = wr; reqWdata = wd;
    #1;
    while (!reqReady) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    #1;
    rd = rspData; pen = rspWakePenalty; vld = rspValid;
  endtask

  task automatic waitEdges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic pulseSleepAll();
    sleepAll = 1'b1;
    @(negedge clk);
    sleepAll = 1'b0;
    #1;
  endtask

  task automatic tReset();
    #1;
    check("R1 rspValid", rspValid, 0);
    check("R1 reqReady", reqReady, 1);
    check("R1 asleepCount", asleepCount, 0);
  endtask

  task automatic tAwake();
    int s; logic [DW-1:0] d; bit p, v;
    doReq(3, 1, 32'hA5A5_0003, s, d, p, v);
    check("R2 write stall", s, 0);
    check("R2 write rspValid", v, 1);
    check("R2 write echo", d, 32'hA5A5_0003);
    doReq(0, 1, 32'h0000_C0DE, s, d, p, v);
    doReq(3, 0, '0, s, d, p, v);
    check("R2 read stall", s, 0);
    check("R2 read data", d, 32'hA5A5_0003);
    check("R2 read penalty", p, 0);
    // response gone one cycle later with no new request
    waitEdges(1);
    check("R2 rspValid drops", rspValid, 0);
  endtask

  task automatic tSleepAll();
    int s; logic [DW-1:0] d; bit p, v;
    doReq(3, 0, '0, s, d, p, v);
    pulseSleepAll();
    check("R8 flagged line spared", asleepCount, NL - 1);
    check("R10 count after first pulse", asleepCount, NL - 1);
    pulseSleepAll();
    check("R7 all asleep", asleepCount, NL);
  endtask

  task automatic tWake();
    int s; logic [DW-1:0] d; bit p, v;
    doReq(3, 0, '0, s, d, p, v);
    check("R5 stall cycles", s, WL + 1);
    check("R5 penalty", p, 1);
    check("R6 retained data", d, 32'hA5A5_0003);
    check("R10 count after wake", asleepCount, NL - 1);
    doReq(3, 0, '0, s, d, p, v);
    check("R11 no second stall", s, 0);
    check("R11 no second penalty", p, 0);
  endtask

  task automatic tTimeout();
    // last access to line 3 just accepted
    waitEdges(IDLE);
    check("R3 not early", asleepCount, NL - 1);
    waitEdges(1);
    check("R3 sleeps on time", asleepCount, NL);
  endtask

  task automatic tRestart();
    int s; logic [DW-1:0] d; bit p, v;
    doReq(3, 0, '0, s, d, p, v);
    waitEdges(IDLE - 10);
    check("R4 awake mid-window", asleepCount, NL - 1);
    doReq(3, 0, '0, s, d, p, v);
    check("R4 refresh no stall", s, 0);
    waitEdges(IDLE);
    check("R4 window restarted", asleepCount, NL - 1);
    waitEdges(1);
    check("R4 sleeps after new window", asleepCount, NL);
  endtask

  task automatic tKeepAwake();
    int s; logic [DW-1:0] d; bit p, v;
    doReq(5, 0, '0, s, d, p, v);
    check("R9 wake under no hold", s, WL + 1);
    keepAwake = 1'b1;
    waitEdges(IDLE + 5);
    check("R9 timeout blocked", asleepCount, NL - 1);
    pulseSleepAll();
    check("R9 sleepAll blocked", asleepCount, NL - 1);
    doReq(6, 0, '0, s, d, p, v);
    check("R9 sleeper still stalls", s, WL + 1);
    check("R9 two awake", asleepCount, NL - 2);
    keepAwake = 1'b0;
    waitEdges(IDLE + 2);
    check("R9 sleeps after release", asleepCount, NL);
  endtask

  task automatic tWriteWake();
    int s; logic [DW-1:0] d; bit p, v;
    doReq(6, 1, 32'h1234_5678, s, d, p, v);
    check("R6 write wake stall", s, WL + 1);
    check("R6 write wake penalty", p, 1);
    waitEdges(1);
    pulseSleepAll();
    check("R7 back to sleep", asleepCount, NL);
    doReq(6, 0, '0, s, d, p, v);
    check("R6 written data kept", d, 32'h1234_5678);
    doReq(0, 0, '0, s, d, p, v);
    check("R6 other line kept", d, 32'h0000_C0DE);
    check("R5 other line penalty", p, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAwake();
    tSleepAll();
    tWake();
    tTimeout();
    tRestart();
    tKeepAwake();
    tWriteWake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule